// File: doc/BRIEF.md
# Multi-mode Keccak sponge hash unit

This block is a single-block Keccak sponge engine built around one 1600-bit permutation core. A two-bit mode input selects one of four functions: SHA3-256, SHA3-512, SHAKE-128 or SHAKE-256. A start pulse loads a message of fewer bytes than the selected rate. The block adds the domain suffix and the pad10*1 padding, absorbs the result into a zeroed state and runs the 24 permutation rounds, one round per clock. It then holds the rate portion of the state, truncated to the digest length, on its output.

In the two extendable-output modes a squeeze pulse runs the permutation once more on the held state and presents the next output block. The round constants are stored as 7-bit codes and are expanded to 64-bit lane constants as the rounds run. Messages longer than one rate block are not absorbed, and the block does not buffer input.

Top module: `keccak_sponge`

## Requirements
- R1: After reset, busy_o and done_o are low and digest_o is all zero.
- R2: An accepted start or squeeze raises busy_o at the next clock edge. busy_o then stays high for exactly 24 cycles. done_o is high for exactly the one cycle after busy_o falls.
- R3: Mode encoding is 0 = SHA3-256, 1 = SHA3-512, 2 = SHAKE-128, 3 = SHAKE-256. Message byte i is msg_i[8i+7:8i]. For a SHA3 mode, state byte i (lane i/8 with lanes ordered x+5y, little-endian within the lane) is loaded as follows before the permutation: message byte i for i < msg_len_i, the value 0x06 at byte msg_len_i, the value 0x80 ORed into byte rate-1, and zero everywhere else. The two pad bytes combine when msg_len_i = rate-1. Message bytes at or beyond msg_len_i have no effect.
- R4: In the SHAKE modes the byte at position msg_len_i is 0x1F instead of 0x06. The rest of the padding follows R3.
- R5: The rates are 136, 72, 168 and 136 bytes for modes 0 to 3. digest_o carries state bits [N-1:0] with N = 256, 512, 1344 and 1088 for modes 0 to 3, and all bits above N are zero.
- R6: The permutation is Keccak-f[1600] with theta, rho, pi, chi and iota applied in order. For the empty message, digest lane 0 is 64'h66d71ebff8c6ffa7 (mode 0), 64'hc59a3aa2cc739fa6 (mode 1), 64'h7d828fe8a42b9c7f (mode 2) and 64'h138da80b2bddb946 (mode 3).
- R7: In a SHAKE mode, a squeeze accepted after a completed absorb or squeeze applies one more permutation to the full 1600-bit state. The output is the next block, masked as in R5.
- R8: A squeeze is ignored in the SHA3 modes, and before any absorb has completed since reset. busy_o stays low and digest_o is unchanged.
- R9: A start with msg_len_i greater than or equal to the selected rate in bytes is ignored. busy_o stays low and digest_o is unchanged.
- R10: While busy_o is high, start and squeeze are ignored. The running permutation finishes with its original result, and no further permutation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Absorb msg_i as a new single-block message |
| mode_i | input | 2 | Function select, sampled at start |
| msg_len_i | input | 8 | Message length in bytes |
| msg_i | input | 1344 | Message bytes, byte 0 in the low bits |
| squeeze_i | input | 1 | Request the next output block (SHAKE modes) |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle pulse when a permutation finishes |
| digest_o | output | 1344 | Masked rate portion of the state once a result is ready |

## Verification
The block has no top-level parameters. Its state width, round count and rates are fixed by the sponge construction, so the bench builds the one configuration there is and covers all four modes through the mode input. The scoreboard model pads and permutes independently and computes its round constants from the linear feedback recurrence rather than from a stored table. Known empty-message digests anchor both the model and the design. The stimulus reaches the edge lengths 0 and rate-1 in every rate class, over-length starts, chained squeezes, and requests issued in the middle of a permutation.

// File: rtl/keccak_pkg.sv
`timescale 1ns/1ps
package keccak_pkg;
  localparam int LANES          = 25;
  localparam int LANE_W         = 64;
  localparam int STATE_W        = LANES * LANE_W;
  localparam int ROUNDS         = 24;
  localparam int CNT_W          = $clog2(ROUNDS);
  localparam int RC_W           = 7;
  localparam int MAX_RATE_BYTES = 168;
  localparam int MSG_W          = MAX_RATE_BYTES * 8;
  localparam int LEN_W          = $clog2(MAX_RATE_BYTES + 1);

  typedef logic [LANES-1:0][LANE_W-1:0] state_t;

  typedef enum logic [1:0] {
    MODE_SHA3_256 = 2'd0,
    MODE_SHA3_512 = 2'd1,
    MODE_SHAKE128 = 2'd2,
    MODE_SHAKE256 = 2'd3
  } mode_e;

  function automatic int rate_bytes(mode_e m);
    case (m)
      MODE_SHA3_256: return 136;
      MODE_SHA3_512: return 72;
      MODE_SHAKE128: return 168;
      default:       return 136;
    endcase
  endfunction

  function automatic int out_bits(mode_e m);
    case (m)
      MODE_SHA3_256: return 256;
      MODE_SHA3_512: return 512;
      MODE_SHAKE128: return 1344;
      default:       return 1088;
    endcase
  endfunction

  function automatic logic is_xof(mode_e m);
    return m[1];
  endfunction

  // rho offset for lane index x+5y, from the (x,y) walk
  function automatic int rho_off(int idx);
    int x, y, nx, t;
    x = 1;
    y = 0;
    if (idx == 0) return 0;
    for (t = 0; t < 24; t++) begin
      if (x + 5 * y == idx) return ((t + 1) * (t + 2) / 2) % 64;
      nx = y;
      y  = (2 * x + 3 * y) % 5;
      x  = nx;
    end
    return 0;
  endfunction

  // bit j of the code lands at lane bit 2^j - 1
  function automatic logic [RC_W-1:0] rc_code(int r);
    case (r)
      0:  return 7'h01;  1:  return 7'h1A;  2:  return 7'h5E;  3:  return 7'h70;
      4:  return 7'h1F;  5:  return 7'h21;  6:  return 7'h79;  7:  return 7'h55;
      8:  return 7'h0E;  9:  return 7'h0C;  10: return 7'h35;  11: return 7'h26;
      12: return 7'h3F;  13: return 7'h4F;  14: return 7'h5D;  15: return 7'h53;
      16: return 7'h52;  17: return 7'h48;  18: return 7'h16;  19: return 7'h66;
      20: return 7'h79;  21: return 7'h58;  22: return 7'h21;  23: return 7'h74;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/keccak_rc.sv
`timescale 1ns/1ps
module keccak_rc
  import keccak_pkg::*;
(
  input  logic [CNT_W-1:0]  round_i,
  output logic [LANE_W-1:0] rc_o
);
  logic [RC_W-1:0] code;

  always_comb begin
    code = rc_code(int'(round_i));
    rc_o = '0;
    for (int j = 0; j < RC_W; j++) rc_o[(1 << j) - 1] = code[j];
  end
endmodule

// File: rtl/keccak_pad.sv
`timescale 1ns/1ps
module keccak_pad
  import keccak_pkg::*;
(
  input  mode_e            mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [MSG_W-1:0] msg_i,
  output state_t           state_o,
  output logic             len_ok_o
);
  logic [STATE_W-1:0] flat;
  logic [7:0]         sfx;
  logic [7:0]         byte_v;
  int                 rb;

  always_comb begin
    rb     = rate_bytes(mode_i);
    sfx    = is_xof(mode_i) ? 8'h1F : 8'h06;
    flat   = '0;
    byte_v = '0;
    for (int i = 0; i < MAX_RATE_BYTES; i++) begin
      byte_v = (i < int'(len_i)) ? msg_i[8*i +: 8] : 8'h00;
      if (i == int'(len_i)) byte_v = byte_v | sfx;
      if (i == rb - 1)      byte_v = byte_v | 8'h80;
      if (i < rb)           flat[8*i +: 8] = byte_v;
    end
    len_ok_o = int'(len_i) < rb;
  end

  assign state_o = state_t'(flat);
endmodule

// File: rtl/keccak_round.sv
`timescale 1ns/1ps
module keccak_round
  import keccak_pkg::*;
(
  input  state_t            state_i,
  input  logic [LANE_W-1:0] rc_i,
  output state_t            state_o
);
  logic [4:0][LANE_W-1:0] col;
  logic [4:0][LANE_W-1:0] dlt;
  state_t                 a_t;
  state_t                 b_p;

  // theta
  always_comb begin
    for (int x = 0; x < 5; x++) begin
      col[x] = '0;
      for (int y = 0; y < 5; y++) col[x] = col[x] ^ state_i[x + 5*y];
    end
    for (int x = 0; x < 5; x++)
      dlt[x] = col[(x + 4) % 5] ^ {col[(x + 1) % 5][LANE_W-2:0], col[(x + 1) % 5][LANE_W-1]};
    for (int i = 0; i < LANES; i++) a_t[i] = state_i[i] ^ dlt[i % 5];
  end

  // rho and pi
  for (genvar i = 0; i < LANES; i++) begin : g_rho_pi
    localparam int X   = i % 5;
    localparam int Y   = i / 5;
    localparam int DST = Y + 5 * ((2 * X + 3 * Y) % 5);
    localparam int OFF = rho_off(i);
    if (OFF == 0) begin : g_plain
      assign b_p[DST] = a_t[i];
    end else begin : g_rot
      assign b_p[DST] = {a_t[i][LANE_W-1-OFF:0], a_t[i][LANE_W-1:LANE_W-OFF]};
    end
  end

  // chi and iota
  always_comb begin
    for (int y = 0; y < 5; y++)
      for (int x = 0; x < 5; x++)
        state_o[x + 5*y] = b_p[x + 5*y] ^ (~b_p[(x + 1) % 5 + 5*y] & b_p[(x + 2) % 5 + 5*y]);
    state_o[0] = state_o[0] ^ rc_i;
  end
endmodule

// File: rtl/keccak_sponge.sv
`timescale 1ns/1ps
module keccak_sponge
  import keccak_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] msg_len_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic             squeeze_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [MSG_W-1:0] digest_o
);
  state_t            pad_state;
  state_t            round_out;
  state_t            state_q;
  logic              len_ok;
  logic [LANE_W-1:0] rc;
  mode_e             mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q, ready_q;
  logic              start_acc, sqz_acc;
  logic [MSG_W-1:0]  out_mask;
  logic [STATE_W-1:0] flat_q;

  keccak_pad u_pad (
    .mode_i   (mode_e'(mode_i)),
    .len_i    (msg_len_i),
    .msg_i    (msg_i),
    .state_o  (pad_state),
    .len_ok_o (len_ok)
  );

  keccak_rc u_rc (
    .round_i (cnt_q),
    .rc_o    (rc)
  );

  keccak_round u_round (
    .state_i (state_q),
    .rc_i    (rc),
    .state_o (round_out)
  );

  assign start_acc = start_i && !busy_q && len_ok;
  assign sqz_acc   = squeeze_i && !start_acc && !busy_q && ready_q && is_xof(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      mode_q  <= MODE_SHA3_256;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        state_q <= pad_state;
        mode_q  <= mode_e'(mode_i);
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
      end else if (sqz_acc) begin
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
      end else if (busy_q) begin
        state_q <= round_out;
        if (cnt_q == CNT_W'(ROUNDS - 1)) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          ready_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < MSG_W; i++) out_mask[i] = i < out_bits(mode_q);
  end

  assign flat_q   = state_q;
  assign digest_o = ready_q ? (flat_q[MSG_W-1:0] & out_mask) : '0;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R2

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < ROUNDS)); // R2

  AST_LAUNCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) || ($past(squeeze_i) && is_xof(mode_q)))); // R8

  AST_LEN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(squeeze_i))
      |-> (int'($past(msg_len_i)) < rate_bytes(mode_e'($past(mode_i))))); // R9

  AST_SHA3_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SHA3_512) |-> (digest_o[MSG_W-1:512] == '0)); // R5

  AST_NO_OUTPUT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (digest_o == '0)); // R10
endmodule

// File: tb/keccak_sponge_bench.sv
`timescale 1ns/1ps
module keccak_sponge_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [7:0]    len = 8'd0;
  logic [1343:0] msg = '0;
  logic          sqz = 1'b0;
  logic          busy_o, done_o;
  logic [1343:0] digest_o;

  always #5 clk = ~clk;

  keccak_sponge u_keccak_sponge (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .msg_len_i(len), .msg_i(msg), .squeeze_i(sqz),
    .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
  );

  int checks = 0;
  int fails  = 0;
  int busy_cnt = 0;
  logic [1343:0] exp_q[$];
  string         tag_q[$];
  logic [1599:0] ref_state;
  logic [1343:0] held;

  task automatic check(bit ok, string req, logic [1343:0] act, logic [1343:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // ---------------- reference model ----------------
  function automatic int ref_rate(int m);
    return (m == 0) ? 136 : (m == 1) ? 72 : (m == 2) ? 168 : 136;
  endfunction

  function automatic int ref_outbits(int m);
    return (m == 0) ? 256 : (m == 1) ? 512 : (m == 2) ? 1344 : 1088;
  endfunction

  function automatic bit lfsr_bit(int t);
    int r;
    r = 1;
    for (int i = 0; i < t % 255; i++) begin
      r = r << 1;
      if ((r & 'h100) != 0) r = r ^ 'h171;
    end
    return r[0];
  endfunction

  function automatic logic [63:0] ref_rc(int rnd);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < 7; j++) v[(1 << j) - 1] = lfsr_bit(j + 7 * rnd);
    return v;
  endfunction

  function automatic logic [63:0] rl(logic [63:0] v, int n);
    if (n == 0) return v;
    return (v << n) | (v >> (64 - n));
  endfunction

  function automatic logic [1599:0] ref_perm(logic [1599:0] s);
    logic [63:0] a[5][5];
    logic [63:0] b[5][5];
    logic [63:0] c[5];
    logic [63:0] d[5];
    int rho[25] = '{0, 1, 62, 28, 27, 36, 44, 6, 55, 20, 3, 10, 43, 25, 39,
                    41, 45, 15, 21, 8, 18, 2, 61, 56, 14};
    logic [1599:0] o;
    for (int x = 0; x < 5; x++)
      for (int y = 0; y < 5; y++) a[x][y] = s[64*(x + 5*y) +: 64];
    for (int r = 0; r < 24; r++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x][0] ^ a[x][1] ^ a[x][2] ^ a[x][3] ^ a[x][4];
      for (int x = 0; x < 5; x++) d[x] = c[(x + 4) % 5] ^ rl(c[(x + 1) % 5], 1);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++) a[x][y] = a[x][y] ^ d[x];
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++) b[y][(2*x + 3*y) % 5] = rl(a[x][y], rho[x + 5*y]);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x][y] = b[x][y] ^ (~b[(x + 1) % 5][y] & b[(x + 2) % 5][y]);
      a[0][0] = a[0][0] ^ ref_rc(r);
    end
    for (int x = 0; x < 5; x++)
      for (int y = 0; y < 5; y++) o[64*(x + 5*y) +: 64] = a[x][y];
    return o;
  endfunction

  function automatic logic [1599:0] ref_pad(int m, int l, logic [1343:0] mg);
    logic [1599:0] s;
    int rb;
    rb = ref_rate(m);
    s = '0;
    for (int i = 0; i < l; i++) s[8*i +: 8] = mg[8*i +: 8];
    s[8*l +: 8] = s[8*l +: 8] ^ ((m >= 2) ? 8'h1F : 8'h06);
    s[8*(rb - 1) +: 8] = s[8*(rb - 1) +: 8] ^ 8'h80;
    return s;
  endfunction

  function automatic logic [1343:0] ref_out(logic [1599:0] s, int m);
    logic [1343:0] r;
    for (int i = 0; i < 1344; i++) r[i] = s[i] && (i < ref_outbits(m));
    return r;
  endfunction

  function automatic logic [1343:0] rnd_msg(int seed);
    logic [1343:0] v;
    logic [31:0] x;
    x = 32'h9E3779B9 ^ seed;
    for (int i = 0; i < 42; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      v[32*i +: 32] = x;
    end
    return v;
  endfunction

  // ---------------- driver ----------------
  task automatic launch(int m, int l, logic [1343:0] mg, string tag);
    ref_state = ref_perm(ref_pad(m, l, mg));
    exp_q.push_back(ref_out(ref_state, m));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    mode = 2'(m); len = 8'(l); msg = mg; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; msg = ~mg;
  endtask

  task automatic squeeze(int m);
    ref_state = ref_perm(ref_state);
    exp_q.push_back(ref_out(ref_state, m));
    tag_q.push_back("R7");
    @(posedge clk); #1 sqz = 1'b1;
    @(posedge clk); #1 sqz = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) busy_cnt++;
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected done", digest_o, '0);
        end else begin
          logic [1343:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(digest_o == e, t, digest_o, e);
        end
        check(busy_cnt == 24, "R2 busy length", 1344'(busy_cnt), 1344'(24));
        busy_cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy_o && !done_o && digest_o == '0, "R1 reset state",
          {busy_o, done_o, digest_o[1341:0]}, '0);

    // R8: squeeze before any absorb
    @(posedge clk); #1 sqz = 1'b1; mode = 2'd2;
    @(posedge clk); #1 sqz = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy_o && digest_o == '0, "R8 squeeze before absorb", digest_o, '0);

    // R6 known answers, empty message, all modes
    launch(0, 0, '0, "R3"); wait_idle();
    check(digest_o[63:0] == 64'h66d71ebff8c6ffa7, "R6 sha3-256 empty", digest_o, 1344'h66d71ebff8c6ffa7);
    check(digest_o[1343:256] == '0, "R5 sha3-256 truncation", digest_o, '0);
    launch(1, 0, '0, "R3"); wait_idle();
    check(digest_o[63:0] == 64'hc59a3aa2cc739fa6, "R6 sha3-512 empty", digest_o, 1344'hc59a3aa2cc739fa6);
    launch(2, 0, '0, "R4"); wait_idle();
    check(digest_o[63:0] == 64'h7d828fe8a42b9c7f, "R6 shake128 empty", digest_o, 1344'h7d828fe8a42b9c7f);
    launch(3, 0, '0, "R4"); wait_idle();
    check(digest_o[63:0] == 64'h138da80b2bddb946, "R6 shake256 empty", digest_o, 1344'h138da80b2bddb946);
    check(digest_o[1343:1088] == '0, "R5 shake256 truncation", digest_o, '0);

    // R3/R4 lengths incl. rate-1 boundary, garbage above length
    launch(0, 5,   rnd_msg(1), "R3"); wait_idle();
    launch(0, 135, rnd_msg(2), "R3"); wait_idle();
    launch(1, 71,  rnd_msg(3), "R3"); wait_idle();
    launch(1, 33,  rnd_msg(4), "R3"); wait_idle();
    launch(2, 167, rnd_msg(5), "R4"); wait_idle();
    launch(3, 135, rnd_msg(6), "R4"); wait_idle();
    launch(3, 100, rnd_msg(7), "R4"); wait_idle();

    // R7 squeezes
    launch(2, 40, rnd_msg(8), "R4"); wait_idle();
    squeeze(2); wait_idle();
    squeeze(2); wait_idle();
    launch(3, 12, rnd_msg(9), "R4"); wait_idle();
    mode = 2'd0; // latched mode governs the squeeze
    squeeze(3); wait_idle();

    // R8: squeeze in SHA3 mode ignored
    launch(0, 64, rnd_msg(10), "R3"); wait_idle();
    held = digest_o;
    @(posedge clk); #1 sqz = 1'b1;
    @(posedge clk); #1 sqz = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && digest_o == held, "R8 squeeze in sha3 mode", digest_o, held);

    // R9: over-length start ignored
    @(posedge clk); #1 mode = 2'd0; len = 8'd136; msg = rnd_msg(11); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy_o && digest_o == held, "R9 len=rate sha3-256", digest_o, held);
    @(posedge clk); #1 mode = 2'd2; len = 8'd168; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy_o && digest_o == held, "R9 len=rate shake128", digest_o, held);
    @(posedge clk); #1 mode = 2'd1; len = 8'd72; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy_o && digest_o == held, "R9 len=rate sha3-512", digest_o, held);

    // R10: requests while busy ignored
    launch(2, 20, rnd_msg(12), "R10");
    repeat (5) @(posedge clk);
    #1 mode = 2'd0; len = 8'd3; msg = rnd_msg(13); start = 1'b1; sqz = 1'b1;
    @(posedge clk); #1 start = 1'b0; sqz = 1'b0;
    wait_idle();
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0 && !busy_o, "R10 no extra run", 1344'(exp_q.size()), '0);

    finish_run();
  end
endmodule